// File: doc/BRIEF.md
# Double-Buffered Serial Receiver with Overrun Protection

This block receives asynchronous serial characters and hands them to a processor through a single holding register. A hidden shift stage samples the line with a 16x oversampling tick, checks the start bit, and assembles eight data bits, least significant first. Once the last data bit has been shifted in, the character moves into the holding register in one transfer, and a one-cycle receive interrupt pulse announces it.

No ready bit can be polled. Software learns that a character has arrived only from the interrupt pulse, and it frees the holding register with a read strobe. If a second character finishes while the holding register is still unread, the older character stays in place, the new one is dropped, and a sticky overrun flag is set. A low line level where the stop bit belongs sets a sticky framing flag. A dedicated clear input or reset releases both flags.

Top module: `dbuf_uart_rx`

## Requirements
- R1: After reset, `data_o` is 0x00 and `irq_o`, `overrun_o` and `frame_err_o` are all low.
- R2: The frame is one low start bit, then 8 data bits with the least significant bit first, then one high stop bit, with no parity. Each bit lasts 16 ticks of `os_tick_i`. Each received character appears unchanged on `data_o`.
- R3: Every transfer into the holding register produces `irq_o` high for exactly one clock cycle. No other event raises `irq_o`.
- R4: A low level on `rx_i` that ends before the middle of the start bit (8 ticks) is rejected. It yields no character and no interrupt.
- R5: If a character finishes while the holding register is unread, `overrun_o` is set, `data_o` keeps the older character, and no interrupt is raised.
- R6: A one-cycle pulse on `rd_i` empties the holding register. The next character then loads normally without setting `overrun_o`.
- R7: A low `rx_i` at the middle of the stop bit sets `frame_err_o`. The character is still transferred when the holding register is free.
- R8: `overrun_o` and `frame_err_o` stay set until a pulse on `flag_clr_i` or a reset. Reading does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_i | input | 1 | Asynchronous serial input; idles high |
| os_tick_i | input | 1 | One-cycle strobe at 16 times the bit rate |
| rd_i | input | 1 | Read strobe that frees the holding register |
| flag_clr_i | input | 1 | Clears the sticky overrun and framing flags |
| data_o | output | 8 | Contents of the holding register |
| irq_o | output | 1 | One-cycle receive interrupt pulse |
| overrun_o | output | 1 | Sticky overrun flag |
| frame_err_o | output | 1 | Sticky framing-error flag |

## Verification
A wrong bit counter or sample phase shows on `data_o` at the interrupt that ends the same frame: the bits come out shifted or duplicated. A stale full marker shows up within one frame, either as a missing interrupt with a spurious `overrun_o`, or as the older character being overwritten. A flag that is not sticky drops one cycle after it was set, and a check on the idle line after the frame catches it. A start check that is too eager produces an extra interrupt about one character time after a short glitch.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic line_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], rx_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign line_o = sync_q[STAGES-1];
  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter
  import uart_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              fall_i,
  output logic [DATA_W-1:0] char_o,
  output logic              done_o,
  output logic              stop_bad_o
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OS_RATE/2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OS_RATE - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              done_q, done_d;
  logic              bad_q, bad_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shift_d = shift_q;
    done_d  = 1'b0;
    bad_d   = 1'b0;
    case (state_q)
      RX_IDLE: begin
        if (fall_i) begin
          state_d = RX_START;
          cnt_d   = '0;
        end
      end
      RX_START: begin
        if (tick_i) begin
          if (cnt_q == HALF_LAST) begin
            cnt_d = '0;
            if (!line_i) begin
              state_d = RX_DATA;
              idx_d   = '0;
            end else begin
              state_d = RX_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (tick_i) begin
          if (cnt_q == FULL_LAST) begin
            cnt_d   = '0;
            shift_d = {line_i, shift_q[DATA_W-1:1]};
            if (idx_q == IDX_LAST) begin
              done_d  = 1'b1;
              state_d = RX_STOP;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_STOP: begin
        if (tick_i) begin
          if (cnt_q == FULL_LAST) begin
            cnt_d   = '0;
            bad_d   = ~line_i;
            state_d = RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      done_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shift_q <= shift_d;
      done_q  <= done_d;
      bad_q   <= bad_d;
    end
  end

  assign char_o     = shift_q;
  assign done_o     = done_q;
  assign stop_bad_o = bad_q;

  // R4: a start bit that is high again at its middle sends the FSM back to idle
  a_r4_glitch_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && tick_i && cnt_q == HALF_LAST && line_i) |=> state_q == RX_IDLE);

  // R3: the end-of-character strobe never lasts more than one cycle
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: the stop-bit verdict comes only after the FSM has returned to idle
  a_r7_bad_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q |-> state_q == RX_IDLE);
endmodule

// File: rtl/rx_holding.sv
module rx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] char_i,
  input  logic              load_i,
  input  logic              bad_i,
  input  logic              rd_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              irq_o,
  output logic              ovr_o,
  output logic              fe_o
);
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              full_q, full_d;
  logic              irq_q, irq_d;
  logic              ovr_q, ovr_d;
  logic              fe_q, fe_d;
  logic              busy;

  always_comb begin
    busy   = full_q & ~rd_i;
    hold_d = hold_q;
    full_d = busy;
    irq_d  = 1'b0;
    if (load_i && !busy) begin
      hold_d = char_i;
      full_d = 1'b1;
      irq_d  = 1'b1;
    end
    ovr_d = (ovr_q & ~clr_i) | (load_i & busy);
    fe_d  = (fe_q & ~clr_i) | bad_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
      ovr_q  <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      hold_q <= hold_d;
      full_q <= full_d;
      irq_q  <= irq_d;
      ovr_q  <= ovr_d;
      fe_q   <= fe_d;
    end
  end

  assign data_o = hold_q;
  assign irq_o  = irq_q;
  assign ovr_o  = ovr_q;
  assign fe_o   = fe_q;

  // R5: a character arriving at an unread register leaves it untouched and raises overrun
  a_r5_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && full_q && !rd_i) |=> ($stable(hold_q) && !irq_q && ovr_q));

  // R6: a read in the same cycle as a new character lets the character load
  a_r6_read_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && rd_i) |=> irq_q);

  // R3: the interrupt is a single-cycle pulse
  a_r3_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R8: the flags hold until cleared
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clr_i) |=> ovr_q);
  a_r8_fe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_q && !clr_i) |=> fe_q);
endmodule

// File: rtl/dbuf_uart_rx.sv
module dbuf_uart_rx #(
  parameter int DATA_W      = 8,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              os_tick_i,
  input  logic              rd_i,
  input  logic              flag_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              irq_o,
  output logic              overrun_o,
  output logic              frame_err_o
);
  logic              line_s;
  logic              fall_s;
  logic [DATA_W-1:0] char_s;
  logic              done_s;
  logic              bad_s;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_i   (rx_i),
    .line_o (line_s),
    .fall_o (fall_s)
  );

  rx_shifter #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (os_tick_i),
    .line_i     (line_s),
    .fall_i     (fall_s),
    .char_o     (char_s),
    .done_o     (done_s),
    .stop_bad_o (bad_s)
  );

  rx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .char_i (char_s),
    .load_i (done_s),
    .bad_i  (bad_s),
    .rd_i   (rd_i),
    .clr_i  (flag_clr_i),
    .data_o (data_o),
    .irq_o  (irq_o),
    .ovr_o  (overrun_o),
    .fe_o   (frame_err_o)
  );
endmodule

// File: tb/dbuf_uart_rx_test.sv
module dbuf_uart_rx_test;
  localparam int TICK_DIV = 2;
  localparam int BIT_CYC  = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       tick = 1'b0;
  logic       rd_auto = 1'b0;
  logic       rd_req = 1'b0;
  logic       clr = 1'b0;
  logic       rd;
  logic [7:0] data;
  logic       irq, ovr, fe;

  int  n_cmp = 0;
  int  n_bad = 0;
  int  irq_cnt = 0;
  int  tick_cnt = 0;
  bit  auto_read = 1'b1;
  bit  finished = 1'b0;
  logic       irq_prev = 1'b0;
  logic [7:0] exp_q[$];

  assign rd = rd_auto | rd_req;

  dbuf_uart_rx uut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .os_tick_i(tick), .rd_i(rd),
    .flag_clr_i(clr), .data_o(data), .irq_o(irq), .overrun_o(ovr), .frame_err_o(fe)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
    tick     <= (tick_cnt == 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: compares each interrupt with the scoreboard queue
  always @(negedge clk) begin
    rd_auto <= 1'b0;
    if (irq && irq_prev) check(1'b0, "R3 irq longer than one cycle", 1, 0);
    if (irq) begin
      irq_cnt++;
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected irq", int'(data), 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(data == e, "R2 received character", int'(data), int'(e));
      end
      if (auto_read) rd_auto <= 1'b1;
    end
    irq_prev <= irq;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit stop_lvl, input bit expect_it);
    if (expect_it) exp_q.push_back(b);
    rx = 1'b0; idle(BIT_CYC);
    for (int i = 0; i < 8; i++) begin rx = b[i]; idle(BIT_CYC); end
    rx = stop_lvl; idle(BIT_CYC);
    rx = 1'b1; idle(2 * BIT_CYC);
  endtask

  task automatic pulse_rd();
    rd_req = 1'b1; idle(1); rd_req = 1'b0; idle(2);
  endtask

  task automatic pulse_clr();
    clr = 1'b1; idle(1); clr = 1'b0; idle(2);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    int base;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    // R1 reset state
    check(data == 8'h00, "R1 data after reset", int'(data), 0);
    check(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
    check(ovr == 1'b0, "R1 overrun after reset", int'(ovr), 0);
    check(fe == 1'b0, "R1 framing after reset", int'(fe), 0);

    // R2 several patterns, LSB first; R6 reads keep overrun low
    send(8'hA5, 1'b1, 1'b1);
    send(8'h01, 1'b1, 1'b1);
    send(8'h80, 1'b1, 1'b1);
    send(8'hFF, 1'b1, 1'b1);
    send(8'h00, 1'b1, 1'b1);
    check(irq_cnt == 5, "R3 one irq per character", irq_cnt, 5);
    check(ovr == 1'b0, "R6 no overrun when each character is read", int'(ovr), 0);
    check(fe == 1'b0, "R7 no framing error on good stop", int'(fe), 0);

    // R4 short glitch rejected
    base = irq_cnt;
    rx = 1'b0; idle(4); rx = 1'b1;
    idle(12 * BIT_CYC);
    check(irq_cnt == base, "R4 glitch gives no character", irq_cnt, base);

    // R5 overrun keeps the older character
    auto_read = 1'b0;
    base = irq_cnt;
    send(8'h3C, 1'b1, 1'b1);
    send(8'hC3, 1'b1, 1'b0);
    check(irq_cnt == base + 1, "R5 no irq for dropped character", irq_cnt, base + 1);
    check(data == 8'h3C, "R5 older character kept", int'(data), 8'h3C);
    check(ovr == 1'b1, "R5 overrun flagged", int'(ovr), 1);

    // R6 read frees the register, R8 overrun survives the read
    pulse_rd();
    auto_read = 1'b1;
    send(8'h5A, 1'b1, 1'b1);
    check(data == 8'h5A, "R6 loads after read", int'(data), 8'h5A);
    check(ovr == 1'b1, "R8 overrun sticky across reads", int'(ovr), 1);
    pulse_clr();
    check(ovr == 1'b0, "R8 overrun cleared by clear input", int'(ovr), 0);

    // R7 framing error: character still delivered, flag sticky
    send(8'h96, 1'b0, 1'b1);
    check(fe == 1'b1, "R7 framing error flagged", int'(fe), 1);
    check(data == 8'h96, "R7 character delivered despite bad stop", int'(data), 8'h96);
    send(8'h42, 1'b1, 1'b1);
    check(fe == 1'b1, "R8 framing flag sticky", int'(fe), 1);
    pulse_clr();
    check(fe == 1'b0, "R8 framing flag cleared", int'(fe), 0);

    check(exp_q.size() == 0, "R2 all expected characters delivered", exp_q.size(), 0);
    report();
  end
endmodule